// File: doc/BRIEF.md
# Background Memory Scrub Scheduler

This block paces background scrub reads across a programmed window of memory. Software loads four registers over a simple write port: a control word, a range start address, a range end address and a scrub pattern. The block watches a tick that pulses once per DRAM refresh period. When background mode is selected and the interval is non-zero, it raises a scrub request for one 64-byte block after every `interval` refresh ticks. The request carries the block address and the pattern word.

The memory scheduler takes the request with a one-cycle acknowledge. The address then moves on by one block. Once the address has reached or passed the end address, it returns to the start address. Only one request is outstanding at a time. Refresh ticks that arrive while a request waits for its acknowledge are dropped, so the pace never runs ahead of the scheduler.

A write to the control register restarts the scrub: it clears the interval count, drops any pending request and loads the current address from the start register. The scrub bandwidth is about 64 bytes times the refresh rate divided by the interval.

Top module: `scrub_sched`

## Requirements
- R1: Register select encoding is 0 control, 1 start, 2 end, 3 pattern. In the control word, bits 31:30 hold the mode, and the value 01 selects background scrubbing. Bits 23:16 hold the interval.
- R2: No request is raised while the mode is not 01 or the interval is 0, whatever ticks arrive.
- R3: With interval N, the request output becomes valid on the clock edge that samples the Nth accepted tick counted from the last restart or the last acknowledge.
- R4: Ticks that arrive while a request is valid, including one in the same cycle as the acknowledge, are not counted.
- R5: A valid request keeps its address stable and stays valid until it is acknowledged or the control register is written. An acknowledge with no valid request has no effect.
- R6: On an acknowledged request whose address is below the end address, the next address is the old address plus 64.
- R7: On an acknowledged request whose address is greater than or equal to the end address, the next address is the start address.
- R8: A control register write clears the interval count and any pending request, and loads the current address from the start register.
- R9: Start and end addresses are stored with bits 5:0 forced to zero, so every request address is 64-byte aligned.
- R10: The request pattern output always shows the last value written to the pattern register.
- R11: After reset, every register is zero, no request is valid, and the address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 control, 1 start, 2 end, 3 pattern) |
| reg_wdata_i | input | 32 | Register write data |
| refresh_tick_i | input | 1 | One-cycle pulse per DRAM refresh period |
| ack_i | input | 1 | Scheduler accepts the current request |
| req_valid_o | output | 1 | Scrub request pending |
| req_addr_o | output | 32 | Block address of the scrub request |
| req_pattern_o | output | 32 | Scrub pattern word |

## Verification
Directed sequences set the interval to 3 and count ticks one at a time. This shows whether the request rises on exactly the Nth tick and not one tick early or late. Ticks are sent during an outstanding request, and one tick lands in the same cycle as the acknowledge; these separate a counter that pauses from one that keeps running. A short window with a start address that is not aligned exercises both the step and the wrap. Disabled mode codes and a zero interval are tried with ticks present. A random phase then mixes control, range and pattern writes, small and zero intervals, windows with the end address below the start address, and acknowledges with no request. Every output is compared each cycle against a bench model of the requirements.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned MODE_HI = 31;
  localparam int unsigned MODE_LO = 30;
  localparam int unsigned INTV_HI = 23;
  localparam int unsigned INTV_LO = 16;
  localparam logic [1:0]  MODE_BACKGROUND = 2'b01;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_END   = 2'd2,
    SEL_PAT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/scrub_regs.sv
module scrub_regs
  import scrub_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BLK_LSB = 6,
  parameter int unsigned INTV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              en_o,
  output logic [INTV_W-1:0] interval_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o,
  output logic [WORD_W-1:0] pattern_o,
  output logic              ctrl_wr_o
);
  localparam int unsigned MODE_W = MODE_HI - MODE_LO + 1;

  logic [MODE_W-1:0] mode_q;
  logic [INTV_W-1:0] intv_q;
  logic [ADDR_W-1:0] start_q, end_q;
  logic [WORD_W-1:0] pat_q;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      intv_q  <= '0;
      start_q <= '0;
      end_q   <= '0;
      pat_q   <= '0;
    end else if (we_i) begin
      unique case (sel)
        SEL_CTRL: begin
          mode_q <= wdata_i[MODE_HI:MODE_LO];
          intv_q <= wdata_i[INTV_HI:INTV_LO];
        end
        SEL_START: start_q <= {wdata_i[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
        SEL_END:   end_q   <= {wdata_i[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
        SEL_PAT:   pat_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign en_o       = (mode_q == MODE_BACKGROUND) && (intv_q != '0);
  assign interval_o = intv_q;
  assign start_o    = start_q;
  assign end_o      = end_q;
  assign pattern_o  = pat_q;
  assign ctrl_wr_o  = we_i && (sel == SEL_CTRL);
endmodule

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int unsigned INTV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              busy_i,
  input  logic              restart_i,
  input  logic [INTV_W-1:0] interval_i,
  output logic              fire_o
);
  localparam logic [INTV_W-1:0] ONE = INTV_W'(1);

  logic [INTV_W-1:0] cnt_q;
  logic              take;
  logic              last;

  // ticks seen while a request waits are dropped
  assign take   = tick_i && en_i && !busy_i && !restart_i;
  assign last   = (cnt_q == interval_i - ONE);
  assign fire_o = take && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (take)       cnt_q <= last ? '0 : cnt_q + ONE;
  end
endmodule

// File: rtl/scrub_tracker.sv
module scrub_tracker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              fire_i,
  input  logic              ack_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BLK_BYTES);

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done;

  assign done = valid_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (restart_i) begin
      valid_q <= 1'b0;
      addr_q  <= start_i;
    end else if (done) begin
      valid_q <= 1'b0;
      addr_q  <= (addr_q >= end_i) ? start_i : addr_q + STEP;
    end else if (fire_i) begin
      valid_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/scrub_sched.sv
module scrub_sched
  import scrub_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 64,
  parameter int unsigned INTV_W    = INTV_HI - INTV_LO + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              refresh_tick_i,
  input  logic              ack_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [WORD_W-1:0] req_pattern_o
);
  localparam int unsigned BLK_LSB = $clog2(BLK_BYTES);

  logic              sched_en;
  logic              ctrl_wr;
  logic              fire;
  logic [INTV_W-1:0] interval;
  logic [ADDR_W-1:0] start_addr, end_addr;

  scrub_regs #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .INTV_W(INTV_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .en_o       (sched_en),
    .interval_o (interval),
    .start_o    (start_addr),
    .end_o      (end_addr),
    .pattern_o  (req_pattern_o),
    .ctrl_wr_o  (ctrl_wr)
  );

  scrub_pacer #(.INTV_W(INTV_W)) u_pacer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (refresh_tick_i),
    .en_i       (sched_en),
    .busy_i     (req_valid_o),
    .restart_i  (ctrl_wr),
    .interval_i (interval),
    .fire_o     (fire)
  );

  scrub_tracker #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ctrl_wr),
    .fire_i    (fire),
    .ack_i     (ack_i),
    .start_i   (start_addr),
    .end_i     (end_addr),
    .valid_o   (req_valid_o),
    .addr_o    (req_addr_o)
  );
endmodule

// File: rtl/scrub_sched_chk.sv
module scrub_sched_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              req_valid_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              sched_en,
  input logic              ctrl_wr,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] end_addr
);
  localparam int unsigned BLK_LSB = $clog2(BLK_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BLK_BYTES);

  p_idle_stays_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_o && !sched_en) |=> !req_valid_o);

  p_hold_until_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !ack_i && !ctrl_wr) |=> (req_valid_o && $stable(req_addr_o)));

  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && ack_i && !ctrl_wr && req_addr_o < end_addr)
      |=> (!req_valid_o && req_addr_o == $past(req_addr_o) + STEP));

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && ack_i && !ctrl_wr && req_addr_o >= end_addr)
      |=> (!req_valid_o && req_addr_o == $past(start_addr)));

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (!req_valid_o && req_addr_o == $past(start_addr)));

  p_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_addr_o[BLK_LSB-1:0] == '0);
endmodule

bind scrub_sched scrub_sched_chk #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .req_valid_o (req_valid_o),
  .req_addr_o  (req_addr_o),
  .sched_en    (sched_en),
  .ctrl_wr     (ctrl_wr),
  .start_addr  (start_addr),
  .end_addr    (end_addr)
);

// File: tb/sim_scrub_sched.sv
module sim_scrub_sched;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic        tick = 1'b0;
  logic        ack = 1'b0;
  logic        vld;
  logic [31:0] addr;
  logic [31:0] pat;

  int checks = 0;
  int errors = 0;

  // model state derived from the requirements
  logic [1:0]  m_mode = '0;
  logic [7:0]  m_intv = '0;
  logic [31:0] m_start = '0, m_end = '0, m_pat = '0, m_addr = '0;
  logic [7:0]  m_cnt = '0;
  logic        m_valid = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  scrub_sched u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .reg_we_i       (we),
    .reg_sel_i      (sel),
    .reg_wdata_i    (wdata),
    .refresh_tick_i (tick),
    .ack_i          (ack),
    .req_valid_o    (vld),
    .req_addr_o     (addr),
    .req_pattern_o  (pat)
  );

  function automatic logic [31:0] align(input logic [31:0] a);
    return {a[31:6], 6'd0};
  endfunction

  function automatic logic [31:0] next_addr(input logic [31:0] a, input logic [31:0] s,
                                            input logic [31:0] e);
    return (a >= e) ? s : a + 32'd64;
  endfunction

  task automatic model_step(input logic w, input logic [1:0] s, input logic [31:0] d,
                            input logic t, input logic k);
    logic en;
    logic [31:0] os = m_start, oe = m_end;
    en = (m_mode == 2'b01) && (m_intv != 0);
    if (w && s == 2'd0) begin
      m_mode = d[31:30]; m_intv = d[23:16];
      m_cnt = 0; m_valid = 1'b0; m_addr = os;
      return;
    end
    if (w && s == 2'd1) m_start = align(d);
    if (w && s == 2'd2) m_end = align(d);
    if (w && s == 2'd3) m_pat = d;
    if (m_valid) begin
      if (k) begin m_valid = 1'b0; m_addr = next_addr(m_addr, os, oe); end
    end else if (t && en) begin
      if (m_cnt == m_intv - 8'd1) begin m_cnt = 0; m_valid = 1'b1; end
      else m_cnt = m_cnt + 8'd1;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (vld !== m_valid || addr !== m_addr || pat !== m_pat) begin
      errors++;
      $display("FAIL %s actual valid=%0b addr=%h pat=%h expected valid=%0b addr=%h pat=%h",
               tag, vld, addr, pat, m_valid, m_addr, m_pat);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] s, input logic [31:0] d,
                     input logic t, input logic k, input string tag);
    we = w; sel = s; wdata = d; tick = t; ack = k;
    @(posedge clk);
    model_step(w, s, d, t, k);
    @(negedge clk);
    we = 0; tick = 0; ack = 0;
    compare(tag);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d, input string tag);
    cyc(1'b1, s, d, 1'b0, 1'b0, tag);
  endtask

  task automatic tk(input string tag);
    cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, tag);
  endtask

  task automatic ak(input logic t, input string tag);
    cyc(1'b0, 2'd0, '0, t, 1'b1, tag);
  endtask

  task automatic expect_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic expect_word(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    expect_bit(vld, 1'b0, "R11 valid");
    expect_word(addr, 32'h0, "R11 addr");
    expect_word(pat, 32'h0, "R11 pattern");

    // R9 unaligned start is trimmed; R10 pattern shown
    wr(2'd1, 32'h0000_1013, "R9");
    wr(2'd2, 32'h0000_1080, "R9");
    wr(2'd3, 32'hA5A5_5A5A, "R10");
    expect_word(pat, 32'hA5A5_5A5A, "R10 pattern");
    wr(2'd0, 32'h4003_0000, "R1");
    expect_word(addr, 32'h0000_1000, "R9 aligned start");

    // R3 interval 3
    tk("R3"); tk("R3");
    expect_bit(vld, 1'b0, "R3 not before third tick");
    tk("R3");
    expect_bit(vld, 1'b1, "R3 valid on third tick");
    // R4/R5 ticks while busy are dropped
    tk("R4"); tk("R4"); tk("R4"); tk("R5");
    expect_word(addr, 32'h0000_1000, "R5 stable addr");
    ak(1'b1, "R4");
    expect_word(addr, 32'h0000_1040, "R6 step");
    tk("R4"); tk("R4");
    expect_bit(vld, 1'b0, "R4 tick at ack not counted");
    tk("R3");
    expect_bit(vld, 1'b1, "R3 refire");
    ak(1'b0, "R6");
    expect_word(addr, 32'h0000_1080, "R6 step to end");
    tk("R3"); tk("R3"); tk("R3");
    ak(1'b0, "R7");
    expect_word(addr, 32'h0000_1000, "R7 wrap");
    ak(1'b0, "R5");
    expect_word(addr, 32'h0000_1000, "R5 ack without request");

    // R8 restart drops pending request
    tk("R3"); tk("R3"); tk("R3");
    wr(2'd1, 32'h0000_2000, "R8");
    wr(2'd0, 32'h4003_0000, "R8");
    expect_bit(vld, 1'b0, "R8 request dropped");
    expect_word(addr, 32'h0000_2000, "R8 addr reload");

    // R2 disabled modes and zero interval
    wr(2'd0, 32'h8001_0000, "R2");
    for (int i = 0; i < 5; i++) tk("R2");
    expect_bit(vld, 1'b0, "R2 mode 10");
    wr(2'd0, 32'h4000_0000, "R2");
    for (int i = 0; i < 5; i++) tk("R2");
    expect_bit(vld, 1'b0, "R2 interval 0");
    wr(2'd0, 32'h4001_0000, "R1");
    tk("R1");
    expect_bit(vld, 1'b1, "R1 interval 1");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic        w = ($urandom % 20) == 0;
      logic [1:0]  s = 2'($urandom % 4);
      logic [31:0] d = $urandom;
      if (s == 2'd0) begin
        d[31:30] = (($urandom % 4) != 0) ? 2'b01 : 2'($urandom);
        d[23:16] = 8'($urandom % 5);
      end else if (s != 2'd3) begin
        d = 32'h0000_4000 + 32'(($urandom % 8) * 64) + 32'($urandom % 64);
      end
      cyc(w, s, d, ($urandom % 2) == 0, ($urandom % 3) == 0, "R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule